// File: doc/BRIEF.md
# Coprocessor Error Interrupt Gating

This block sits between the interrupt and I/O side of a chipset and a processor's legacy floating-point error handshake. The processor drives an active-low numeric error input. While the error function is switched on by an enable bit in a general control register, the block raises a level request on the internal IRQ13 line toward the interrupt controller. The error handler later writes to the coprocessor error register, which the address decoder at I/O port F0h presents here as a single write strobe.

A strobe that arrives while the error is active asserts the active-low ignore-numeric-error output to the processor. The output then releases itself once the processor negates its error line. It therefore behaves as a gated set, self-clearing latch and not as a software bit. While reset is held, the ignore pin instead carries a frequency strap level for the processor to sample.

The error input is asynchronous to the bus clock and passes through a two-flop synchroniser before any logic uses it.

Top module: `cop_err_gate`

## Requirements
- R1: Polarities: `numErrN` low means a numeric error is reported; `ignoreErrN` low means the processor is told to ignore the error; `irq13Req` is active high.
- R2: A change on `numErrN` is seen by the logic only after two rising clock edges of synchronisation. `irq13Req` follows a change made between edges on the third rising edge after it.
- R3: While `errFnEn` is 1, `irq13Req` is 1 exactly when the synchronised error is active, and 0 otherwise.
- R4: A rising edge with `cerWrStb` = 1, `errFnEn` = 1 and the synchronised error active drives `ignoreErrN` low right after that edge.
- R5: Once low, `ignoreErrN` stays low while the error remains active and the enable stays set, whether or not more writes arrive.
- R6: When `numErrN` returns high, `ignoreErrN` goes high on the third rising edge after the change, with no write needed.
- R7: A write while the synchronised error is inactive leaves `ignoreErrN` high, and a later error does not set it. This includes a write one edge after `numErrN` falls, before synchronisation completes.
- R8: While `errFnEn` is 0, `irq13Req` is 0 and `ignoreErrN` is high regardless of writes. Clearing the enable while `ignoreErrN` is low releases it on the next edge.
- R9: While `rstN` is low, `ignoreErrN` equals `strapIgnHigh` (1 drives high, 0 drives low), `irq13Req` is 0 and writes are ignored. After release, `ignoreErrN` is high until a qualifying write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| numErrN | input | 1 | Active-low numeric error from the processor, asynchronous |
| errFnEn | input | 1 | Error function enable from the general control register |
| cerWrStb | input | 1 | One-cycle write strobe to the coprocessor error register |
| strapIgnHigh | input | 1 | Strap level driven on the ignore pin during reset |
| ignoreErrN | output | 1 | Active-low ignore-numeric-error to the processor |
| irq13Req | output | 1 | Level IRQ13 request to the interrupt controller |

## Verification
The hardest case to reach from the ports is a write that lands while the error pin is already low but the synchroniser has not yet passed it through. The bench drops `numErrN` and pulses the strobe on the very next edge. It then holds the error active and checks that the ignore output never asserts. A second hard case is a write arriving during reset with the error active and the enable set, which is followed by a release. The bench creates it by driving all qualifying inputs while `rstN` is low and checking the pin right after release.

// File: rtl/cop_err_pkg.sv
package cop_err_pkg;

  localparam int SyncStages = 2;

  typedef struct packed {
    logic setIgn;
    logic clrIgn;
  } ignStrobe_t;

endpackage

// File: rtl/cop_err_ctl.sv
module cop_err_ctl
  import cop_err_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       errFnEn,
  input  logic       cerWrStb,
  input  logic       errAct,
  input  logic       ignLatched,
  output ignStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (!errFnEn || !errAct) begin
      strobe.clrIgn = 1'b1;
    end else if (cerWrStb) begin
      strobe.setIgn = 1'b1;
    end
  end

  assert_set_excl_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setIgn && strobe.clrIgn));

  assert_no_set_without_error_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setIgn |-> (errAct && errFnEn));

  assert_clear_when_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!errFnEn && ignLatched) |-> strobe.clrIgn);

endmodule

// File: rtl/cop_err_path.sv
module cop_err_path
  import cop_err_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       numErrN,
  input  logic       errFnEn,
  input  logic       cerWrStb,
  input  ignStrobe_t strobe,
  output logic       errAct,
  output logic       ignLatched,
  output logic       irqLevel
);

  logic [SyncStages-1:0] syncChain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SyncStages-2:0], ~numErrN};
  end

  assign errAct = syncChain[SyncStages-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ignLatched <= 1'b0;
    else if (strobe.clrIgn) ignLatched <= 1'b0;
    else if (strobe.setIgn) ignLatched <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqLevel <= 1'b0;
    else       irqLevel <= errFnEn & errAct;
  end

  assert_set_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (errFnEn && cerWrStb && errAct) |=> ignLatched);

  assert_hold_while_error_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ignLatched && errFnEn && errAct) |=> ignLatched);

  assert_auto_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ignLatched && !errAct) |=> !ignLatched);

  assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ignLatched && !errAct) |=> !ignLatched);

  assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (errFnEn && errAct) |=> irqLevel);

  assert_irq_off_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    !errFnEn |=> (!irqLevel && !ignLatched));

endmodule

// File: rtl/cop_err_gate.sv
module cop_err_gate
  import cop_err_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic numErrN,
  input  logic errFnEn,
  input  logic cerWrStb,
  input  logic strapIgnHigh,
  output logic ignoreErrN,
  output logic irq13Req
);

  ignStrobe_t strobe;
  logic       errAct;
  logic       ignLatched;
  logic       irqLevel;

  cop_err_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .errFnEn    (errFnEn),
    .cerWrStb   (cerWrStb),
    .errAct     (errAct),
    .ignLatched (ignLatched),
    .strobe     (strobe)
  );

  cop_err_path uPath (
    .clk        (clk),
    .rstN       (rstN),
    .numErrN    (numErrN),
    .errFnEn    (errFnEn),
    .cerWrStb   (cerWrStb),
    .strobe     (strobe),
    .errAct     (errAct),
    .ignLatched (ignLatched),
    .irqLevel   (irqLevel)
  );

  assign ignoreErrN = rstN ? ~ignLatched : strapIgnHigh;
  assign irq13Req   = irqLevel;

  assert_pin_deasserted_unless_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    !errFnEn |=> ignoreErrN);

endmodule

// File: tb/cop_err_gate_test.sv
module cop_err_gate_test;

  logic clk = 1'b0;
  logic rstN, numErrN, errFnEn, cerWrStb, strapIgnHigh;
  logic ignoreErrN, irq13Req;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  cop_err_gate uut (
    .clk          (clk),
    .rstN         (rstN),
    .numErrN      (numErrN),
    .errFnEn      (errFnEn),
    .cerWrStb     (cerWrStb),
    .strapIgnHigh (strapIgnHigh),
    .ignoreErrN   (ignoreErrN),
    .irq13Req     (irq13Req)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic resetScenario();
    rstN = 1'b0; numErrN = 1'b0; errFnEn = 1'b1; cerWrStb = 1'b1;
    strapIgnHigh = 1'b1;
    #1;
    check("R9", "strap high drives pin high", ignoreErrN, 1'b1);
    strapIgnHigh = 1'b0;
    #1;
    check("R9", "strap low drives pin low", ignoreErrN, 1'b0);
    tick(3);
    check("R9", "irq held low in reset", irq13Req, 1'b0);
    cerWrStb = 1'b0;
    rstN = 1'b1;
    #1;
    check("R9", "pin high after release", ignoreErrN, 1'b1);
    tick(3);
    check("R9", "write in reset left no set", ignoreErrN, 1'b1);
    numErrN = 1'b1;
    tick(4);
  endtask

  task automatic latencyScenario();
    numErrN = 1'b0;
    tick(2);
    check("R2", "irq not yet after two edges", irq13Req, 1'b0);
    tick(1);
    check("R2", "irq after third edge", irq13Req, 1'b1);
    check("R3", "irq follows error", irq13Req, 1'b1);
  endtask

  task automatic setHoldClearScenario();
    cerWrStb = 1'b1;
    tick(1);
    cerWrStb = 1'b0;
    check("R4", "write with error sets ignore", ignoreErrN, 1'b0);
    tick(5);
    check("R5", "ignore held while error", ignoreErrN, 1'b0);
    cerWrStb = 1'b1;
    tick(1);
    cerWrStb = 1'b0;
    check("R5", "extra write keeps ignore", ignoreErrN, 1'b0);
    numErrN = 1'b1;
    tick(2);
    check("R6", "ignore held during sync", ignoreErrN, 1'b0);
    tick(1);
    check("R6", "ignore auto cleared", ignoreErrN, 1'b1);
    check("R3", "irq dropped with error", irq13Req, 1'b0);
  endtask

  task automatic noErrorWriteScenario();
    cerWrStb = 1'b1;
    tick(1);
    cerWrStb = 1'b0;
    check("R7", "write without error", ignoreErrN, 1'b1);
    numErrN = 1'b0;
    tick(4);
    check("R7", "later error does not set", ignoreErrN, 1'b1);
    numErrN = 1'b1;
    tick(4);
    numErrN = 1'b0;
    cerWrStb = 1'b1;
    tick(1);
    cerWrStb = 1'b0;
    tick(4);
    check("R7", "write before sync completes", ignoreErrN, 1'b1);
    check("R1", "error low gives irq high", irq13Req, 1'b1);
  endtask

  task automatic disableScenario();
    errFnEn = 1'b0;
    tick(1);
    check("R8", "irq off when disabled", irq13Req, 1'b0);
    cerWrStb = 1'b1;
    tick(1);
    cerWrStb = 1'b0;
    check("R8", "write ignored when disabled", ignoreErrN, 1'b1);
    errFnEn = 1'b1;
    tick(1);
    check("R3", "irq back when enabled", irq13Req, 1'b1);
    cerWrStb = 1'b1;
    tick(1);
    cerWrStb = 1'b0;
    check("R4", "set again", ignoreErrN, 1'b0);
    errFnEn = 1'b0;
    tick(1);
    check("R8", "disable releases ignore", ignoreErrN, 1'b1);
    check("R8", "disable drops irq", irq13Req, 1'b0);
  endtask

  task automatic midResetScenario();
    errFnEn = 1'b1;
    cerWrStb = 1'b1;
    tick(1);
    cerWrStb = 1'b0;
    check("R4", "set before reset", ignoreErrN, 1'b0);
    strapIgnHigh = 1'b1;
    rstN = 1'b0;
    #1;
    check("R9", "reset shows strap", ignoreErrN, 1'b1);
    tick(1);
    rstN = 1'b1;
    #1;
    check("R9", "reset cleared ignore", ignoreErrN, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    resetScenario();
    latencyScenario();
    setHoldClearScenario();
    noErrorWriteScenario();
    disableScenario();
    midResetScenario();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule